// File: doc/BRIEF.md
# Supply Protection and Restart Supervisor

This block is the digital supervisor of a switching power stage. It watches digitized comparator flags on the supply rail and a set of fault flags, and decides whether the power switch may operate and whether the high-voltage startup source should charge the supply capacitor. It applies undervoltage lockout with hysteresis: switching starts at the turn-on level and stops at the turn-off level. The startup source is on while the rail charges and off while the converter runs.

Faults come in two classes. An auto-restart fault halts switching. It is forgotten once the rail collapses to the turn-off level, so the normal charge and run sequence repeats. A latched fault also halts switching, but it survives rail hiccups. Each fall to the turn-off level turns the startup source back on. Each rise to the turn-on level turns it off again without switching. Only a fall to the lower de-latch level clears the fault.

Supply overvoltage is debounced over a run of consecutive clocks. Output overvoltage must be seen on a number of consecutive switching-cycle strobes. Over-temperature uses a trip flag and a release flag to form a hysteretic hot state.

Top module: `supply_supervisor`

## Requirements
- R1: After reset the block is in the charging state: `startup_enable`=1, `switch_enable`=0, `fault_auto`=0, `fault_latched`=0.
- R2: From charging, with no latched fault, `sup_above_on`=1 at a clock edge enters running from the next cycle: `switch_enable`=1 and `startup_enable`=0. The two enables are never both 1.
- R3: While running, `sup_below_off`=1 at a clock edge returns the block to charging with no fault flagged.
- R4: While running, `brownout_flag`, `cs_short_flag` or a recognized supply overvoltage enters the auto-restart halt: both enables 0 and `fault_auto`=1.
- R5: In the auto-restart halt, `sup_below_off`=1 clears the fault and returns to charging. A later `sup_above_on` restarts switching.
- R6: Supply overvoltage is recognized on the SOVP_CYCLES-th consecutive clock with `sup_above_ovp`=1. Any clock with the flag low restarts the count.
- R7: While running, `vout_ovp_flag`=1 on VOVP_STROBES consecutive `cycle_strobe` pulses raises a latched fault. A strobe with the flag low restarts the count. The count is cleared whenever the block is not running.
- R8: A hot state is set by `temp_trip_flag` and cleared by `temp_release_flag`; trip wins if both are high. While hot, the block enters the latched halt from charging or running, one cycle after the trip is sampled.
- R9: With a latched fault, `sup_below_off`=1 turns `startup_enable` on and keeps `fault_latched`. `sup_above_on`=1 then turns `startup_enable` off again without switching.
- R10: A latched fault clears only when `sup_below_delatch`=1, which returns the block to charging.
- R11: When a latched and an auto-restart cause occur in the same cycle, the latched fault wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_above_on | input | 1 | Rail is at or above the turn-on level |
| sup_below_off | input | 1 | Rail is at or below the turn-off level |
| sup_below_delatch | input | 1 | Rail is at or below the de-latch level |
| sup_above_ovp | input | 1 | Rail is above its overvoltage level (raw) |
| brownout_flag | input | 1 | Line brownout detected |
| cs_short_flag | input | 1 | Current-sense short detected |
| vout_ovp_flag | input | 1 | Output overvoltage seen this switching cycle |
| temp_trip_flag | input | 1 | Die temperature at or above the trip point |
| temp_release_flag | input | 1 | Die temperature at or below the release point |
| cycle_strobe | input | 1 | One-clock pulse per switching cycle |
| switch_enable | output | 1 | Power switch may operate |
| startup_enable | output | 1 | High-voltage startup source on |
| fault_auto | output | 1 | Auto-restart fault held |
| fault_latched | output | 1 | Latched fault held |

## Verification
The assertions assume a physically ordered rail: `sup_above_on` and `sup_below_off` are never high together, and `sup_below_delatch` implies `sup_below_off`. The stimulus keeps to this by always raising the de-latch flag together with the turn-off flag and never raising the turn-on flag at the same time. The properties also assume that fault flags are sampled only once per clock. The stimulus therefore changes every input on the falling edge and holds pulses for whole clocks. Strobes last a single cycle, as a real per-cycle pulse would.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [2:0] {
    ST_CHARGE    = 3'd0,
    ST_RUN       = 3'd1,
    ST_HALT_AUTO = 3'd2,
    ST_HALT_LAT  = 3'd3,
    ST_LAT_CHG   = 3'd4
  } supv_state_t;
endpackage

// File: rtl/supv_persist.sv
// Counts consecutive steps with the level high; hit fires on the LIMIT-th.
module supv_persist #(
  parameter int unsigned LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic level,
  output logic hit
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign hit = step && level && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (step) begin
      if (!level)          cnt <= '0;
      else if (cnt != TOP) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/supv_thermal.sv
// Hysteretic hot state from separate trip and release comparator flags.
module supv_thermal (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic release_ok,
  output logic hot
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hot <= 1'b0;
    else if (trip)       hot <= 1'b1;
    else if (release_ok) hot <= 1'b0;
  end
endmodule

// File: rtl/supv_fsm.sv
module supv_fsm
  import supv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        above_on,
  input  logic        below_off,
  input  logic        below_delatch,
  input  logic        auto_ev,
  input  logic        latch_ev,
  output supv_state_t state
);
  supv_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_CHARGE: begin
        if (latch_ev)      nxt = ST_HALT_LAT;
        else if (above_on) nxt = ST_RUN;
      end
      ST_RUN: begin
        if (latch_ev)       nxt = ST_HALT_LAT;
        else if (auto_ev)   nxt = ST_HALT_AUTO;
        else if (below_off) nxt = ST_CHARGE;
      end
      ST_HALT_AUTO: begin
        if (below_off) nxt = ST_CHARGE;
      end
      ST_HALT_LAT: begin
        if (below_delatch)  nxt = ST_CHARGE;
        else if (below_off) nxt = ST_LAT_CHG;
      end
      ST_LAT_CHG: begin
        if (below_delatch) nxt = ST_CHARGE;
        else if (above_on) nxt = ST_HALT_LAT;
      end
      default: nxt = ST_CHARGE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_CHARGE;
    else        state <= nxt;
  end
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supv_pkg::*;
#(
  parameter int unsigned SOVP_CYCLES  = 25000,
  parameter int unsigned VOVP_STROBES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_above_on,
  input  logic sup_below_off,
  input  logic sup_below_delatch,
  input  logic sup_above_ovp,
  input  logic brownout_flag,
  input  logic cs_short_flag,
  input  logic vout_ovp_flag,
  input  logic temp_trip_flag,
  input  logic temp_release_flag,
  input  logic cycle_strobe,
  output logic switch_enable,
  output logic startup_enable,
  output logic fault_auto,
  output logic fault_latched
);
  supv_state_t state;
  logic        running;
  logic        sovp_hit;
  logic        vovp_hit;
  logic        hot;
  logic        auto_ev;
  logic        latch_ev;

  assign running = (state == ST_RUN);

  supv_persist #(.LIMIT(SOVP_CYCLES)) u_sovp (
    .clk(clk), .rst_n(rst_n), .clear(1'b0), .step(1'b1),
    .level(sup_above_ovp), .hit(sovp_hit)
  );

  supv_persist #(.LIMIT(VOVP_STROBES)) u_vovp (
    .clk(clk), .rst_n(rst_n), .clear(!running), .step(cycle_strobe),
    .level(vout_ovp_flag), .hit(vovp_hit)
  );

  supv_thermal u_therm (
    .clk(clk), .rst_n(rst_n), .trip(temp_trip_flag),
    .release_ok(temp_release_flag), .hot(hot)
  );

  assign auto_ev  = sovp_hit || brownout_flag || cs_short_flag;
  assign latch_ev = hot || vovp_hit;

  supv_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .above_on(sup_above_on),
    .below_off(sup_below_off), .below_delatch(sup_below_delatch),
    .auto_ev(auto_ev), .latch_ev(latch_ev), .state(state)
  );

  assign switch_enable  = running;
  assign startup_enable = (state == ST_CHARGE) || (state == ST_LAT_CHG);
  assign fault_auto     = (state == ST_HALT_AUTO);
  assign fault_latched  = (state == ST_HALT_LAT) || (state == ST_LAT_CHG);
endmodule

// File: rtl/supv_checker.sv
module supv_checker (
  input logic clk,
  input logic rst_n,
  input logic sup_above_on,
  input logic sup_below_off,
  input logic sup_below_delatch,
  input logic switch_enable,
  input logic startup_enable,
  input logic fault_auto,
  input logic fault_latched
);
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(switch_enable && startup_enable));

  p_start_on_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(switch_enable) |-> $past(sup_above_on));

  p_uvlo_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_enable && sup_below_off) |=> !switch_enable);

  p_one_fault_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_auto && fault_latched));

  p_auto_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_auto && sup_below_off) |=> (!fault_auto && startup_enable));

  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && !sup_below_delatch) |=> (fault_latched && !switch_enable));

  p_latch_on_stops_charge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && startup_enable && sup_above_on && !sup_below_delatch)
      |=> !startup_enable);

  p_delatch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && sup_below_delatch) |=> (!fault_latched && startup_enable));
endmodule

bind supply_supervisor supv_checker chk_i (
  .clk(clk), .rst_n(rst_n), .sup_above_on(sup_above_on),
  .sup_below_off(sup_below_off), .sup_below_delatch(sup_below_delatch),
  .switch_enable(switch_enable), .startup_enable(startup_enable),
  .fault_auto(fault_auto), .fault_latched(fault_latched)
);

// File: tb/supply_supervisor_tb_top.sv
`timescale 1ns/1ps
module supply_supervisor_tb_top;
  localparam int SOVP_N = 8;
  localparam int VOVP_N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above_on = 0, below_off = 0, below_dl = 0, above_ovp = 0;
  logic brown = 0, cs_short = 0, vovp = 0, t_trip = 0, t_rel = 0, strobe = 0;
  logic sw, st, fa, fl;

  int vectors = 0;
  int errors  = 0;
  string tag = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  supply_supervisor #(.SOVP_CYCLES(SOVP_N), .VOVP_STROBES(VOVP_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .sup_above_on(above_on), .sup_below_off(below_off),
    .sup_below_delatch(below_dl), .sup_above_ovp(above_ovp),
    .brownout_flag(brown), .cs_short_flag(cs_short), .vout_ovp_flag(vovp),
    .temp_trip_flag(t_trip), .temp_release_flag(t_rel), .cycle_strobe(strobe),
    .switch_enable(sw), .startup_enable(st), .fault_auto(fa), .fault_latched(fl)
  );

  // Behavioural reference: 0 charge, 1 run, 2 auto halt, 3 latched halt, 4 latched charge
  int m_st, m_srun, m_vcnt;
  bit m_hot;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_srun = 0; m_vcnt = 0; m_hot = 0;
    end else begin
      bit sev, vev, lev, aev;
      int nst;
      sev = above_ovp && (m_srun >= SOVP_N - 1);
      m_srun = above_ovp ? ((m_srun + 1 > SOVP_N - 1) ? SOVP_N - 1 : m_srun + 1) : 0;
      vev = 0;
      if (m_st != 1) m_vcnt = 0;
      else if (strobe) begin
        if (vovp) begin
          vev = (m_vcnt >= VOVP_N - 1);
          m_vcnt = (m_vcnt + 1 > VOVP_N - 1) ? VOVP_N - 1 : m_vcnt + 1;
        end else m_vcnt = 0;
      end
      lev = m_hot || vev;
      aev = sev || brown || cs_short;
      nst = m_st;
      case (m_st)
        0: if (lev) nst = 3; else if (above_on) nst = 1;
        1: if (lev) nst = 3; else if (aev) nst = 2; else if (below_off) nst = 0;
        2: if (below_off) nst = 0;
        3: if (below_dl) nst = 0; else if (below_off) nst = 4;
        default: if (below_dl) nst = 0; else if (above_on) nst = 3;
      endcase
      m_st = nst;
      if (t_trip) m_hot = 1; else if (t_rel) m_hot = 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic esw, est, efa, efl;
      esw = (m_st == 1); est = (m_st == 0 || m_st == 4);
      efa = (m_st == 2); efl = (m_st == 3 || m_st == 4);
      vectors++;
      if ({sw, st, fa, fl} !== {esw, est, efa, efl}) begin
        errors++;
        $display("FAIL %s model compare: got sw/st/fa/fl=%b%b%b%b expected %b%b%b%b",
                 tag, sw, st, fa, fl, esw, est, efa, efl);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(string t, logic esw, logic est, logic efa, logic efl);
    #1;
    vectors++;
    if ({sw, st, fa, fl} !== {esw, est, efa, efl}) begin
      errors++;
      $display("FAIL %s directed: got sw/st/fa/fl=%b%b%b%b expected %b%b%b%b",
               t, sw, st, fa, fl, esw, est, efa, efl);
    end
  endtask

  task automatic pulse_strobe(logic flag);
    vovp = flag; strobe = 1; tick(1);
    strobe = 0; vovp = 0; tick(2);
  endtask

  task automatic go_run();
    above_on = 1; tick(1); above_on = 0; tick(1);
  endtask

  task automatic collapse(logic deep);
    below_off = 1; below_dl = deep; tick(1); below_off = 0; below_dl = 0; tick(1);
  endtask

  initial begin
    tick(3); rst_n = 1; tick(1);
    tag = "R1"; expect_out("R1", 0, 1, 0, 0);

    tag = "R2"; above_on = 1; tick(1); expect_out("R2", 1, 0, 0, 0); above_on = 0; tick(2);

    tag = "R3"; below_off = 1; tick(1); expect_out("R3", 0, 1, 0, 0); below_off = 0; tick(1);
    go_run();

    tag = "R6"; above_ovp = 1; tick(SOVP_N - 1); above_ovp = 0; tick(1);
    expect_out("R6", 1, 0, 0, 0);
    above_ovp = 1; tick(SOVP_N - 1); expect_out("R6", 1, 0, 0, 0);
    tick(1); expect_out("R6", 0, 0, 1, 0); above_ovp = 0; tick(2);

    tag = "R5"; above_on = 1; tick(1); expect_out("R5", 0, 0, 1, 0); above_on = 0;
    below_off = 1; tick(1); expect_out("R5", 0, 1, 0, 0); below_off = 0; tick(1);
    go_run();

    tag = "R4"; brown = 1; tick(1); brown = 0; expect_out("R4", 0, 0, 1, 0); tick(1);
    collapse(0); go_run();
    cs_short = 1; tick(1); cs_short = 0; expect_out("R4", 0, 0, 1, 0); tick(1);
    collapse(0); go_run();

    tag = "R7";
    pulse_strobe(1); pulse_strobe(1); pulse_strobe(0); pulse_strobe(1); pulse_strobe(1);
    expect_out("R7", 1, 0, 0, 0);
    pulse_strobe(1); expect_out("R7", 0, 0, 0, 1);

    tag = "R9";
    repeat (2) begin
      below_off = 1; tick(1); below_off = 0; expect_out("R9", 0, 1, 0, 1); tick(1);
      above_on = 1; tick(1); above_on = 0; expect_out("R9", 0, 0, 0, 1); tick(1);
    end
    tag = "R10"; collapse(1); expect_out("R10", 0, 1, 0, 0);

    tag = "R8"; t_trip = 1; tick(1); t_trip = 0; tick(1); expect_out("R8", 0, 0, 0, 1);
    collapse(1); tick(1); expect_out("R8", 0, 0, 0, 1);
    t_rel = 1; tick(1); t_rel = 0; collapse(1); tick(2); expect_out("R8", 0, 1, 0, 0);
    go_run(); t_trip = 1; t_rel = 1; tick(1); t_trip = 0; t_rel = 0; tick(1);
    expect_out("R8", 0, 0, 0, 1);
    t_rel = 1; tick(1); t_rel = 0; collapse(1); go_run();

    tag = "R11";
    pulse_strobe(1); pulse_strobe(1);
    vovp = 1; strobe = 1; brown = 1; tick(1); vovp = 0; strobe = 0; brown = 0;
    expect_out("R11", 0, 0, 0, 1);
    collapse(1); tick(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule